// File: doc/BRIEF.md
# Reconfigurable Self-Test Register

This block is a register that can take on four roles in a self-test arrangement, chosen each clock by a two-bit mode code. It can act as a plain register capturing the outputs of the logic under test, or as a synchronous clear. It can act as a serial chain that moves bits from a scan input to a scan output. Its fourth role is a linear feedback shift register that both produces pseudorandom patterns and folds parallel responses into a signature.

In the feedback role every stage XORs its parallel input into the value shifted into it. With the parallel inputs held at zero, the register runs as a pattern generator. With live responses on them, it works as a multiple-input signature compactor. The feedback taps come from a parameter mask; the default four-bit width uses the characteristic polynomial x^4 + x^3 + 1. Two instances placed around two logic blocks can trade duties, with one generating patterns while the other compacts responses, and then the reverse. The register contents drive a parallel output at all times, so a signature can be read directly.

Top module: `bist_mode_reg`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, all stages become 0, so `q` reads 0 after reset.
- R2: Mode code 2'b00 loads `par_in` into the register at each edge; `q[i]` then equals the `par_in[i]` of the previous cycle.
- R3: Mode code 2'b01 clears every stage to 0 within a single clock, whatever the value of `par_in`.
- R4: Mode code 2'b11 shifts: `q[0]` takes `scan_in` and `q[i]` takes the old `q[i-1]`. `par_in` has no effect in this mode.
- R5: `scan_out` always equals the last stage, `q[WIDTH-1]`, in every mode.
- R6: In mode code 2'b10 with `par_in` at zero and the default taps, `q[0]` takes `q[2]^q[3]` and `q[i]` takes `q[i-1]`. Written as q[0..3], the seed 0001 steps to 1000, 0100, 0010, 1001, 1100, 0110, 1011 in that order.
- R7: From any nonzero state in mode code 2'b10 with zero input, the default register never reaches all-zero. It returns to its starting state after exactly 15 steps.
- R8: In mode code 2'b10 with nonzero `par_in`, every stage also XORs in its own `par_in` bit: `q[0]` takes feedback^`par_in[0]` and `q[i]` takes `q[i-1]`^`par_in[i]`.
- R9: An all-zero register in mode code 2'b10 with zero `par_in` stays all-zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | 00 load, 01 clear, 10 generate/compact, 11 scan shift |
| par_in | input | WIDTH | Parallel data from the logic under test |
| scan_in | input | 1 | Serial input to stage 0 in scan mode |
| scan_out | output | 1 | Serial output, the last stage |
| q | output | WIDTH | Current register contents (pattern or signature) |

## Verification
The hardest case to reach is the full 15-state cycle of the generator. Getting there needs an exact nonzero seed, followed by a long run in mode 2'b10 with the parallel inputs held at zero throughout. The stimulus plants the seed 0001 with a parallel load, checks the first seven states by value, and then counts steps back to the seed while watching for zero. Compaction is then driven with changing response words from a nonzero state, so every per-stage XOR term reaches the result. Scan shifting is run with parallel inputs toggling, to show that they do not leak into the chain.

// File: rtl/bmr_pkg.sv
// Shared types for the reconfigurable self-test register.
// Assumes the two-bit mode code is sampled every clock.
package bmr_pkg;

    typedef enum logic [1:0] {
        BMR_LOAD  = 2'b00,
        BMR_CLEAR = 2'b01,
        BMR_GEN   = 2'b10,
        BMR_SCAN  = 2'b11
    } bmr_mode_e;

    // Per-stage control lines decoded from the mode code.
    typedef struct packed {
        logic load;   // capture the parallel input
        logic clear;  // force zero
        logic shift;  // take the chain link from the previous stage
        logic mix;    // XOR the parallel input into the shifted bit
    } bmr_ctl_t;

endpackage

// File: rtl/bmr_mode_dec.sv
// Turns the two-bit mode code into per-stage control lines.
// Assumes exactly one line among load/clear/shift is active per code.
module bmr_mode_dec
    import bmr_pkg::*;
(
    input  logic [1:0] mode,
    output bmr_ctl_t   ctl
);

    // Combinational mode decode.
    always_comb begin
        ctl = '0;
        case (bmr_mode_e'(mode))
            BMR_LOAD:  ctl.load  = 1'b1;
            BMR_CLEAR: ctl.clear = 1'b1;
            BMR_GEN: begin
                ctl.shift = 1'b1;
                ctl.mix   = 1'b1;
            end
            BMR_SCAN:  ctl.shift = 1'b1;
            default:   ctl = '0;
        endcase
    end

endmodule

// File: rtl/bmr_feedback.sv
// Feedback bit for the generator: XOR of the stages picked by the tap mask.
// Assumes TAPS bit i selects stage i (stage 0 is the first stage).
module bmr_feedback #(
    parameter int              WIDTH = 4,
    parameter logic [WIDTH-1:0] TAPS = 4'b1100
) (
    input  logic [WIDTH-1:0] state,
    output logic             fb
);

    // Parity over the tapped stages.
    always_comb begin
        fb = ^(state & TAPS);
    end

endmodule

// File: rtl/bmr_stage.sv
// One storage bit of the register with its mode multiplexer.
// Assumes the decoder asserts no more than one of load/clear/shift.
module bmr_stage
    import bmr_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  bmr_ctl_t ctl,
    input  logic     link,
    input  logic     par,
    output logic     bit_q
);

    logic bit_d;

    // Next-value selection for this stage.
    always_comb begin
        if (ctl.clear)
            bit_d = 1'b0;
        else if (ctl.load)
            bit_d = par;
        else if (ctl.shift)
            bit_d = link ^ (ctl.mix & par);
        else
            bit_d = bit_q;
    end

    // Storage flop with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_q <= 1'b0;
        else
            bit_q <= bit_d;
    end

endmodule

// File: rtl/bist_mode_reg.sv
// Reconfigurable self-test register: parallel load, clear, generator or
// signature compactor, and scan chain, chosen by a two-bit mode code.
// Assumes WIDTH >= 2 and a TAPS mask that describes the wanted polynomial.
module bist_mode_reg
    import bmr_pkg::*;
#(
    parameter int               WIDTH = 4,
    parameter logic [WIDTH-1:0] TAPS  = 4'b1100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic             scan_out,
    output logic [WIDTH-1:0] q
);

    localparam int LAST = WIDTH - 1;

    bmr_ctl_t         ctl;
    logic             fb;
    logic [WIDTH-1:0] link;

    bmr_mode_dec u_dec (
        .mode (mode),
        .ctl  (ctl)
    );

    bmr_feedback #(.WIDTH(WIDTH), .TAPS(TAPS)) u_fb (
        .state (q),
        .fb    (fb)
    );

    // Head of the chain: feedback when generating, scan input when scanning.
    always_comb begin
        link[0] = ctl.mix ? fb : scan_in;
    end

    genvar i;
    generate
        for (i = 1; i < WIDTH; i++) begin : g_link
            // Each later stage is fed by its predecessor.
            always_comb begin
                link[i] = q[i-1];
            end
        end
        for (i = 0; i < WIDTH; i++) begin : g_stage
            bmr_stage u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .ctl   (ctl),
                .link  (link[i]),
                .par   (par_in[i]),
                .bit_q (q[i])
            );
        end
    endgenerate

    // Serial output from the last stage.
    always_comb begin
        scan_out = q[LAST];
    end

endmodule

// File: rtl/bmr_checker.sv
// Temporal checks on the self-test register, attached by bind.
// Assumes WIDTH >= 2.
module bmr_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic [WIDTH-1:0] par_in,
    input logic             scan_in,
    input logic [WIDTH-1:0] q
);

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |=> (q == $past(par_in))); // R2

    AST_CLEAR_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01) |=> (q == '0)); // R3

    AST_SCAN_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (q == {$past(q[WIDTH-2:0]), $past(scan_in)})); // R4

    AST_COMPACT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (q[WIDTH-1:1] == ($past(q[WIDTH-2:0]) ^ $past(par_in[WIDTH-1:1])))); // R8

    AST_NO_LOCKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && q != '0 && par_in == '0) |=> (q != '0)); // R7

    AST_ZERO_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && q == '0 && par_in == '0) |=> (q == '0)); // R9

endmodule

bind bist_mode_reg bmr_checker #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .par_in  (par_in),
    .scan_in (scan_in),
    .q       (q)
);

// File: tb/bist_mode_reg_test.sv
// Bench: behavioural reference model stepped beside the register and
// compared after every clock.
module bist_mode_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic [3:0] par_in = 4'h0;
    logic       scan_in = 1'b0;
    logic       scan_out;
    logic [3:0] q;

    int  tests = 0;
    int  fails = 0;
    bit  done  = 1'b0;
    logic [3:0] model = 4'h0;
    string req = "R1";

    always #2 clk = ~clk;

    bist_mode_reg uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode     (mode),
        .par_in   (par_in),
        .scan_in  (scan_in),
        .scan_out (scan_out),
        .q        (q)
    );

    task automatic check(input string r, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // Model of one clock, written from the requirements.
    function automatic logic [3:0] next_of(input logic [3:0] m, input logic [1:0] md,
                                           input logic [3:0] p, input logic s, input logic rn);
        int v;
        int fbit;
        if (!rn) return 4'h0;
        case (md)
            2'b00: return p;
            2'b01: return 4'h0;
            2'b11: return {m[2:0], s};
            default: begin
                fbit = int'(m[2]) ^ int'(m[3]);
                v = ((int'(m) * 2) % 16) + fbit;
                v = v ^ int'(p);
                return v[3:0];
            end
        endcase
    endfunction

    // Apply one clock with the given inputs and compare against the model.
    task automatic tick(input logic [1:0] md, input logic [3:0] p, input logic s);
        mode = md; par_in = p; scan_in = s;
        model = next_of(model, md, p, s, rst_n);
        @(posedge clk);
        @(negedge clk);
        check(req, int'(q), int'(model));
        check("R5", int'(scan_out), int'(model[3]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [3:0] seq [7];
        logic [3:0] seed;
        int steps;
        bit saw_zero;
        @(negedge clk);
        req = "R1";
        tick(2'b00, 4'hA, 1'b1);
        tick(2'b00, 4'h5, 1'b0);
        check("R1", int'(q), 0);
        rst_n = 1'b1;

        req = "R2";
        tick(2'b00, 4'h9, 1'b0);
        tick(2'b00, 4'h6, 1'b1);
        tick(2'b00, 4'hF, 1'b0);

        req = "R3";
        tick(2'b01, 4'hF, 1'b1);
        check("R3", int'(q), 0);

        req = "R4";
        tick(2'b00, 4'h0, 1'b0);
        for (int k = 0; k < 8; k++) tick(2'b11, 4'(k * 5 + 3), 1'((k % 3) == 0));
        check("R4", int'(q), int'(model));

        // Seed 0001 written as q[0..3] means q[0]=0..q[3]=1, i.e. 4'b1000.
        req = "R6";
        tick(2'b00, 4'b1000, 1'b0);
        seq[0] = 4'b0001; seq[1] = 4'b0010; seq[2] = 4'b0100; seq[3] = 4'b1001;
        seq[4] = 4'b0011; seq[5] = 4'b0110; seq[6] = 4'b1101;
        for (int k = 0; k < 7; k++) begin
            tick(2'b10, 4'h0, 1'b0);
            check("R6", int'(q), int'(seq[k]));
        end

        req = "R7";
        tick(2'b00, 4'b1000, 1'b0);
        seed = 4'b1000;
        steps = 0;
        saw_zero = 1'b0;
        do begin
            tick(2'b10, 4'h0, 1'b0);
            steps++;
            if (q == 4'h0) saw_zero = 1'b1;
        end while (q != seed && steps < 40);
        check("R7", steps, 15);
        check("R7", int'(saw_zero), 0);

        req = "R8";
        tick(2'b00, 4'h3, 1'b0);
        tick(2'b10, 4'hC, 1'b0);
        tick(2'b10, 4'h5, 1'b1);
        tick(2'b10, 4'hF, 1'b0);
        tick(2'b10, 4'h1, 1'b0);

        req = "R9";
        tick(2'b01, 4'h0, 1'b0);
        tick(2'b10, 4'h0, 1'b0);
        tick(2'b10, 4'h0, 1'b0);
        check("R9", int'(q), 0);

        req = "R1";
        tick(2'b00, 4'hB, 1'b0);
        rst_n = 1'b0;
        tick(2'b00, 4'h7, 1'b0);
        check("R1", int'(q), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule